// File: doc/BRIEF.md
# Two-Level Decoded Arithmetic Logic Unit

This block is the combinational arithmetic core of a simple processor datapath. It pairs a small control decoder with a WIDTH-bit ALU. The main controller supplies a 2-bit operation class. For register-to-register instructions the decoder also reads the 6-bit function field.

For memory instructions and compare-for-branch instructions, the class alone fixes the operation. For register-type instructions, the decoder hands the choice to the function field. The 3-bit operation select that results drives the ALU. The ALU returns a result and a zero flag, and a branch unit samples the flag after a subtraction to decide equality.

The block holds no state. Every output follows its inputs within the same cycle.

Top module: `alu_decode_core`

## Requirements
- R1: Operation class 2'b00 selects add (op_sel 3'b010), whatever the function field holds.
- R2: Any operation class with bit 0 set (2'b01 or 2'b11) selects subtract (op_sel 3'b110), whatever the function field holds. Bit 0 has priority over bit 1.
- R3: Operation class 2'b10 decodes function bits [3:0]: 4'b0000 add, 4'b0010 subtract, 4'b0100 AND, 4'b0101 OR, 4'b1010 set-on-less-than. Function bits [5:4] have no effect on the result.
- R4: The op_sel output uses this encoding: 3'b000 AND, 3'b001 OR, 3'b010 add, 3'b110 subtract, 3'b111 set-on-less-than. The result is the matching bitwise or arithmetic function of src_a and src_b.
- R5: Set-on-less-than compares src_a and src_b as signed two's-complement values. It returns 1 when src_a is less than src_b and 0 otherwise, with all upper result bits clear.
- R6: zero is high exactly when result is all zeros. After a subtraction, this means zero is high exactly when src_a equals src_b.
- R7: Add and subtract wrap modulo 2^WIDTH, and no overflow indication is produced.
- R8: Under class 2'b10, a function code whose bits [3:0] are not in the R3 list selects add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_class | input | 2 | Operation class from the main controller |
| funct | input | 6 | Function field of a register-type instruction |
| src_a | input | WIDTH | First operand |
| src_b | input | WIDTH | Second operand |
| op_sel | output | 3 | Decoded operation select |
| result | output | WIDTH | ALU result |
| zero | output | 1 | High when result is zero |

## Verification
The bench builds two copies of the block.

The first uses WIDTH=32, the production width. Random operands at this width exercise the full decode table. Directed cases cover the extreme signed values, the all-ones plus one wrap, and subtraction of equal operands.

The second uses WIDTH=8. At this width random operands often land on equality, carry-out, and signed boundaries. That lets the zero flag, the wrap-around and the signed compare be hit often without targeted stimulus.

// File: rtl/alu_decode_core.sv
module alu_decode_core #(
  parameter int WIDTH = 32
) (
  input  logic [1:0]       op_class,
  input  logic [5:0]       funct,
  input  logic [WIDTH-1:0] src_a,
  input  logic [WIDTH-1:0] src_b,
  output logic [2:0]       op_sel,
  output logic [WIDTH-1:0] result,
  output logic             zero
);

  localparam logic [2:0] SEL_AND = 3'b000;
  localparam logic [2:0] SEL_OR  = 3'b001;
  localparam logic [2:0] SEL_ADD = 3'b010;
  localparam logic [2:0] SEL_SUB = 3'b110;
  localparam logic [2:0] SEL_SLT = 3'b111;

  logic [WIDTH-1:0] sum_w;
  logic [WIDTH-1:0] diff_w;
  logic             less_w;

  always_comb begin
    if (op_class[0])
      op_sel = SEL_SUB;
    else if (op_class[1]) begin
      casez (funct)
        6'b??0010: op_sel = SEL_SUB;
        6'b??0100: op_sel = SEL_AND;
        6'b??0101: op_sel = SEL_OR;
        6'b??1010: op_sel = SEL_SLT;
        default:   op_sel = SEL_ADD;
      endcase
    end else
      op_sel = SEL_ADD;
  end

  assign sum_w  = src_a + src_b;
  assign diff_w = src_a - src_b;
  assign less_w = $signed(src_a) < $signed(src_b);

  always_comb begin
    case (op_sel)
      SEL_AND: result = src_a & src_b;
      SEL_OR:  result = src_a | src_b;
      SEL_SUB: result = diff_w;
      SEL_SLT: result = {{(WIDTH-1){1'b0}}, less_w};
      default: result = sum_w;
    endcase
  end

  assign zero = ~|result;

  always_comb begin
    if (!$isunknown({op_class, funct, src_a, src_b})) begin
      AST_MEM_ADD:    assert (op_class != 2'b00 || op_sel == SEL_ADD);                  // R1
      AST_BRANCH_SUB: assert (!op_class[0] || op_sel == SEL_SUB);                       // R2
      AST_AND_SUBSET: assert (op_sel != SEL_AND || (result & ~src_a) == '0);            // R4
      AST_SLT_BOOL:   assert (op_sel != SEL_SLT || result[WIDTH-1:1] == '0);           // R5
      AST_SUB_EQUAL:  assert (op_sel != SEL_SUB || zero == (src_a == src_b));           // R6
    end
  end

endmodule

// File: tb/alu_decode_core_test.sv
module alu_decode_core_test;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [1:0]  op_class;
  logic [5:0]  funct;
  logic [31:0] a32, b32, res32;
  logic [7:0]  a8, b8, res8;
  logic [2:0]  sel32, sel8;
  logic        z32, z8;

  alu_decode_core #(.WIDTH(32)) uut (
    .op_class(op_class), .funct(funct), .src_a(a32), .src_b(b32),
    .op_sel(sel32), .result(res32), .zero(z32));

  alu_decode_core #(.WIDTH(8)) uut8 (
    .op_class(op_class), .funct(funct), .src_a(a8), .src_b(b8),
    .op_sel(sel8), .result(res8), .zero(z8));

  function automatic logic [2:0] exp_sel(logic [1:0] c, logic [5:0] f);
    if (c == 2'b00) return 3'b010;
    if (c[0]) return 3'b110;
    case (f[3:0])
      4'b0000: return 3'b010;
      4'b0010: return 3'b110;
      4'b0100: return 3'b000;
      4'b0101: return 3'b001;
      4'b1010: return 3'b111;
      default: return 3'b010;
    endcase
  endfunction

  function automatic logic [63:0] exp_res(logic [2:0] s, logic [63:0] a, logic [63:0] b, int w);
    logic [63:0] mask, sb;
    mask = (64'd1 << w) - 64'd1;
    sb   = 64'd1 << (w - 1);
    case (s)
      3'b000: return a & b;
      3'b001: return a | b;
      3'b110: return (a + (~b & mask) + 64'd1) & mask;
      3'b111: return ((a ^ sb) < (b ^ sb)) ? 64'd1 : 64'd0;
      default: return (a + b) & mask;
    endcase
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply(string tag, logic [1:0] c, logic [5:0] f,
                       logic [31:0] a, logic [31:0] b, logic [7:0] na, logic [7:0] nb);
    logic [2:0]  s;
    logic [63:0] e32, e8;
    @(negedge clk);
    op_class = c; funct = f; a32 = a; b32 = b; a8 = na; b8 = nb;
    #2;
    s   = exp_sel(c, f);
    e32 = exp_res(s, {32'd0, a}, {32'd0, b}, 32);
    e8  = exp_res(s, {56'd0, na}, {56'd0, nb}, 8);
    check(tag, "op_sel", {61'd0, sel32}, {61'd0, s});
    check(tag, "result32", {32'd0, res32}, e32);
    check("R6", "zero32", {63'd0, z32}, {63'd0, e32 == 64'd0});
    check(tag, "result8", {56'd0, res8}, e8);
    check("R6", "zero8", {63'd0, z8}, {63'd0, e8 == 64'd0});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    op_class = 2'b00; funct = 6'd0; a32 = '0; b32 = '0; a8 = '0; b8 = '0;
    #2;
    check("R6", "idle zero", {63'd0, z32}, 64'd1);
    check("R1", "idle sel", {61'd0, sel32}, 64'd2);

    apply("R7", 2'b00, 6'h3f, 32'hffff_ffff, 32'd1, 8'hff, 8'h01);
    apply("R1", 2'b00, 6'b100101, 32'h1234_5678, 32'h1111_1111, 8'h12, 8'h34);
    apply("R2", 2'b01, 6'b100100, 32'hdead_beef, 32'hdead_beef, 8'h5a, 8'h5a);
    apply("R2", 2'b11, 6'b101010, 32'd5, 32'd9, 8'd5, 8'd9);
    apply("R7", 2'b10, 6'b100010, 32'd0, 32'd1, 8'd0, 8'd1);
    apply("R5", 2'b10, 6'b101010, 32'h8000_0000, 32'h7fff_ffff, 8'h80, 8'h7f);
    apply("R5", 2'b10, 6'b101010, 32'h7fff_ffff, 32'h8000_0000, 8'h7f, 8'h80);
    apply("R5", 2'b10, 6'b001010, 32'hffff_ffff, 32'd0, 8'hff, 8'h00);
    apply("R5", 2'b10, 6'b001010, 32'd3, 32'd3, 8'd3, 8'd3);
    apply("R3", 2'b10, 6'b110101, 32'hf0f0_0000, 32'h0f0f_0001, 8'hf0, 8'h0f);
    apply("R4", 2'b10, 6'b000100, 32'hff00_ff00, 32'h0ff0_0ff0, 8'hc3, 8'h3c);
    apply("R8", 2'b10, 6'b000111, 32'h0000_0010, 32'h0000_0020, 8'h10, 8'h20);
    apply("R8", 2'b10, 6'b111111, 32'h7fff_ffff, 32'd1, 8'h7f, 8'h01);

    for (int i = 0; i < 3000; i++) begin
      logic [1:0] c;
      logic [5:0] f;
      c = 2'($urandom);
      f = (i % 2 == 0) ? 6'($urandom) : {2'($urandom), 4'($urandom % 11)};
      apply((c == 2'b10) ? "R3" : "R4", c, f, $urandom, $urandom, 8'($urandom), 8'($urandom));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule